// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from host memory to a MAC. The host keeps a circular ring of two-word transmit descriptors. Each descriptor points at a buffer, and the host hands a descriptor over by setting its ownership bit. The engine walks the ring in order. For each descriptor it owns, it fetches the buffer one 32-bit word at a time through a simple request/acknowledge memory master. It then presents the bytes to the MAC on a valid/ready byte stream, and marks the last byte of the frame.

A frame may be spread over several consecutive descriptors. The first carries a start flag and the last carries an end flag. When the MAC reports the outcome of the frame (collision count and retry exhaustion), the engine writes that status into the end descriptor, clears its ownership bit and pulses an interrupt. If a descriptor in the middle of a frame is still held by the host, the engine aborts the frame toward the MAC and records an underrun. If a descriptor turns up without a start flag while no frame is open, the engine flags a framing error and skips it.

When the engine finds nothing to send, it re-reads the ownership bit of the current descriptor at a fixed interval. A transmit-demand strobe from the host makes it look at once.

Top module: `txr_dma_engine`

## Requirements
- R1: While reset is applied and just after it, `mem_req`, `tx_valid`, `tx_abort` and `irq` are all 0.
- R2: The engine acts only on a descriptor whose control word has bit 31 (ownership) set to 1. Every word it writes back has bit 31 at 0. A demand on a descriptor with bit 31 at 0 causes no memory write, no byte and no interrupt.
- R3: Descriptor i sits at word address RING_BASE+2*i. The control word holds the buffer length in bytes in bits 11:0, and the next word holds the buffer word address. The buffer is sent in address order, with the lowest byte lane (bits 7:0) of each word first, and exactly as many bytes as the length field gives.
- R4: A frame runs from a descriptor with the start flag (bit 30) to one with the end flag (bit 29). `tx_last` is high only on the final byte of the end descriptor. Each earlier descriptor of the frame is written back with only bit 31 cleared.
- R5: On the end descriptor, after `mac_stat_valid`, the engine writes back the following. Bit 26 (sent OK) is the inverse of `mac_retry_fail`. Bit 25 (retries exhausted) equals `mac_retry_fail`. Bits 23:20 hold `mac_coll`. Bits 28 and 27 are 0. The length, start and end fields are kept.
- R6: `irq` is a single-cycle pulse, raised once for each status write-back: end of frame, framing error or underrun.
- R7: An owned descriptor without the start flag, met while no frame is open, sends no byte. It is written back with bit 28 (error) set and bit 31 cleared. The engine then continues with the next descriptor.
- R8: If the descriptor after a non-end descriptor of an open frame is not owned, `tx_abort` pulses for one cycle and the open frame's last processed descriptor gets bits 28 and 27 (underrun) set. The engine then waits on the non-owned descriptor.
- R9: After index RING_LEN-1 the engine returns to index 0, and it never reads a descriptor outside the ring.
- R10: When idle, the engine re-reads the current control word every POLL_CYCLES cycles, with no demand needed. A `tx_demand` pulse starts that read at once.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_demand | input | 1 | Host strobe: inspect the current descriptor now |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Single-cycle acknowledge |
| tx_valid | output | 1 | Byte available to the MAC |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_abort | output | 1 | Frame aborted by underrun |
| mac_stat_valid | input | 1 | MAC outcome for the last frame |
| mac_coll | input | 4 | Collisions seen on that frame |
| mac_retry_fail | input | 1 | Retry limit reached, frame dropped |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A table of frames drives the main path. The table mixes single-buffer and two-buffer frames, lengths that end on every byte lane and on a word boundary, zero and maximum collision counts, and retry failures. Half of the frames run with a stalling MAC. This separates byte ordering from lane selection, shows that the final-descriptor status is separate from the chained-descriptor clear, and covers the handshake hold rule. The table uses more descriptors than the ring holds, so the wrap to index 0 is also exercised. Directed cases then cover an unowned demand, a missing start flag followed by a good frame, an underrun in the middle of a frame, and a frame picked up by polling alone.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DW      = 32;
  localparam int LEN_W   = 12;
  localparam int OWN_B   = 31;
  localparam int SOP_B   = 30;
  localparam int EOP_B   = 29;
  localparam int ERR_B   = 28;
  localparam int UFLO_B  = 27;
  localparam int OK_B    = 26;
  localparam int RTRY_B  = 25;
  localparam int COLL_LO = 20;
  localparam int COLL_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_CTL, S_RD_PTR, S_RD_WORD, S_SEND, S_WAIT_STAT, S_ABORT, S_WB
  } eng_state_t;

  typedef enum logic [1:0] {
    WB_CLEAR, WB_FINAL, WB_FRAME_ERR, WB_UFLO
  } wb_kind_t;
endpackage

// File: rtl/txr_rst_sync.sv
module txr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int POLL_CYCLES = 64,
  localparam int CW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic demand,
  output logic go
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (!idle || cnt_q == '0) cnt_d = CW'(POLL_CYCLES - 1);
    else                      cnt_d = cnt_q - 1'b1;
    go = idle && (demand || cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CW'(POLL_CYCLES - 1);
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DW-1:0] word,
  input  logic [LW-1:0] sel,
  output logic [7:0]    byte_o
);
  logic [7:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[8*g +: 8];
  end

  assign byte_o = lanes[sel];
endmodule

// File: rtl/txr_status_pack.sv
module txr_status_pack
  import txr_pkg::*;
(
  input  logic [DW-1:0]     base,
  input  wb_kind_t          kind,
  input  logic [COLL_W-1:0] coll,
  input  logic              rtry,
  output logic [DW-1:0]     word
);
  always_comb begin
    word        = base;
    word[OWN_B] = 1'b0;
    unique case (kind)
      WB_CLEAR: ;
      WB_FINAL: begin
        word[ERR_B]                = 1'b0;
        word[UFLO_B]               = 1'b0;
        word[OK_B]                 = !rtry;
        word[RTRY_B]               = rtry;
        word[COLL_LO +: COLL_W]    = coll;
      end
      WB_FRAME_ERR: begin
        word[ERR_B] = 1'b1;
        word[OK_B]  = 1'b0;
      end
      WB_UFLO: begin
        word[ERR_B]  = 1'b1;
        word[UFLO_B] = 1'b1;
        word[OK_B]   = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/txr_dma_engine.sv
module txr_dma_engine
  import txr_pkg::*;
#(
  parameter int AW          = 16,
  parameter int RING_BASE   = 0,
  parameter int RING_LEN    = 8,
  parameter int POLL_CYCLES = 64,
  localparam int IW    = (RING_LEN > 1) ? $clog2(RING_LEN) : 1,
  localparam int LANES = DW / 8,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_demand,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ack,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  output logic              tx_abort,
  input  logic              mac_stat_valid,
  input  logic [COLL_W-1:0] mac_coll,
  input  logic              mac_retry_fail,
  output logic              irq
);
  logic rst_n_s;
  logic poll_go;

  eng_state_t        st_q, st_d;
  wb_kind_t          kind_q, kind_d;
  logic [IW-1:0]     idx_q, idx_d, prev_idx_q, prev_idx_d, idx_nxt;
  logic [DW-1:0]     ctl_q, ctl_d, prev_ctl_q, prev_ctl_d, word_q, word_d;
  logic [AW-1:0]     buf_q, buf_d, wofs_q, wofs_d;
  logic [LW-1:0]     lane_q, lane_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic              in_frame_q, in_frame_d;
  logic [COLL_W-1:0] coll_q, coll_d;
  logic              rtry_q, rtry_d;
  logic              irq_q, irq_d;
  logic [DW-1:0]     wb_base, wb_word;
  eng_state_t        end_st;
  wb_kind_t          end_kind;

  function automatic logic [AW-1:0] desc_addr(input logic [IW-1:0] i);
    return AW'(RING_BASE) + (AW'(i) << 1);
  endfunction

  txr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  txr_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
    .clk(clk), .rst_n(rst_n_s), .idle(st_q == S_IDLE),
    .demand(tx_demand), .go(poll_go)
  );

  txr_byte_lane #(.DW(DW)) u_lane (.word(word_q), .sel(lane_q), .byte_o(tx_data));

  assign wb_base = (kind_q == WB_UFLO) ? prev_ctl_q : ctl_q;

  txr_status_pack u_pack (
    .base(wb_base), .kind(kind_q), .coll(coll_q), .rtry(rtry_q), .word(wb_word)
  );

  assign idx_nxt   = (idx_q == IW'(RING_LEN - 1)) ? '0 : idx_q + 1'b1;
  assign end_st    = ctl_q[EOP_B] ? S_WAIT_STAT : S_WB;
  assign end_kind  = ctl_q[EOP_B] ? kind_q : WB_CLEAR;
  assign mem_wdata = wb_word;
  assign tx_last   = (st_q == S_SEND) && ctl_q[EOP_B] && (left_q == LEN_W'(1));
  assign irq       = irq_q;

  always_comb begin
    st_d       = st_q;
    kind_d     = kind_q;
    idx_d      = idx_q;
    prev_idx_d = prev_idx_q;
    ctl_d      = ctl_q;
    prev_ctl_d = prev_ctl_q;
    word_d     = word_q;
    buf_d      = buf_q;
    wofs_d     = wofs_q;
    lane_d     = lane_q;
    left_d     = left_q;
    in_frame_d = in_frame_q;
    coll_d     = coll_q;
    rtry_d     = rtry_q;
    irq_d      = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = '0;
    tx_valid   = 1'b0;
    tx_abort   = 1'b0;
    unique case (st_q)
      S_IDLE: if (poll_go) st_d = S_RD_CTL;
      S_RD_CTL: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr(idx_q);
        if (mem_ack) begin
          ctl_d = mem_rdata;
          if (!mem_rdata[OWN_B]) begin
            st_d = in_frame_q ? S_ABORT : S_IDLE;
          end else if (!in_frame_q && !mem_rdata[SOP_B]) begin
            kind_d = WB_FRAME_ERR;
            st_d   = S_WB;
          end else begin
            st_d = S_RD_PTR;
          end
        end
      end
      S_RD_PTR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr(idx_q) + 1'b1;
        if (mem_ack) begin
          buf_d      = mem_rdata[AW-1:0];
          wofs_d     = '0;
          lane_d     = '0;
          left_d     = ctl_q[LEN_W-1:0];
          in_frame_d = 1'b1;
          if (ctl_q[LEN_W-1:0] == '0) begin
            st_d   = end_st;
            kind_d = end_kind;
          end else begin
            st_d = S_RD_WORD;
          end
        end
      end
      S_RD_WORD: begin
        mem_req  = 1'b1;
        mem_addr = buf_q + wofs_q;
        if (mem_ack) begin
          word_d = mem_rdata;
          st_d   = S_SEND;
        end
      end
      S_SEND: begin
        tx_valid = 1'b1;
        if (tx_ready) begin
          left_d = left_q - 1'b1;
          if (left_q == LEN_W'(1)) begin
            st_d   = end_st;
            kind_d = end_kind;
          end else if (lane_q == LW'(LANES - 1)) begin
            lane_d = '0;
            wofs_d = wofs_q + 1'b1;
            st_d   = S_RD_WORD;
          end else begin
            lane_d = lane_q + 1'b1;
          end
        end
      end
      S_WAIT_STAT: begin
        if (mac_stat_valid) begin
          coll_d = mac_coll;
          rtry_d = mac_retry_fail;
          kind_d = WB_FINAL;
          st_d   = S_WB;
        end
      end
      S_ABORT: begin
        tx_abort   = 1'b1;
        kind_d     = WB_UFLO;
        in_frame_d = 1'b0;
        st_d       = S_WB;
      end
      S_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = (kind_q == WB_UFLO) ? desc_addr(prev_idx_q) : desc_addr(idx_q);
        if (mem_ack) begin
          unique case (kind_q)
            WB_CLEAR: begin
              prev_idx_d = idx_q;
              prev_ctl_d = wb_word;
              idx_d      = idx_nxt;
              st_d       = S_RD_CTL;
            end
            WB_FINAL: begin
              in_frame_d = 1'b0;
              irq_d      = 1'b1;
              idx_d      = idx_nxt;
              st_d       = S_RD_CTL;
            end
            WB_FRAME_ERR: begin
              irq_d = 1'b1;
              idx_d = idx_nxt;
              st_d  = S_RD_CTL;
            end
            default: begin
              irq_d = 1'b1;
              st_d  = S_IDLE;
            end
          endcase
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q       <= S_IDLE;
      kind_q     <= WB_CLEAR;
      idx_q      <= '0;
      prev_idx_q <= '0;
      in_frame_q <= 1'b0;
      irq_q      <= 1'b0;
      ctl_q      <= '0;
      prev_ctl_q <= '0;
      word_q     <= '0;
      buf_q      <= '0;
      wofs_q     <= '0;
      lane_q     <= '0;
      left_q     <= '0;
      coll_q     <= '0;
      rtry_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      kind_q     <= kind_d;
      idx_q      <= idx_d;
      prev_idx_q <= prev_idx_d;
      in_frame_q <= in_frame_d;
      irq_q      <= irq_d;
      if (mem_ack)                     ctl_q      <= ctl_d;
      if (mem_ack)                     prev_ctl_q <= prev_ctl_d;
      if (mem_ack)                     word_q     <= word_d;
      if (mem_ack)                     buf_q      <= buf_d;
      if (mem_ack || tx_ready)         wofs_q     <= wofs_d;
      if (mem_ack || tx_ready)         lane_q     <= lane_d;
      if (mem_ack || tx_ready)         left_q     <= left_d;
      if (mac_stat_valid)              coll_q     <= coll_d;
      if (mac_stat_valid)              rtry_q     <= rtry_d;
    end
  end
endmodule

// File: rtl/txr_dma_checker.sv
module txr_dma_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_abort,
  input logic          irq
);
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r2_wb_clears_own: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]);

  a_r8_abort_no_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |-> !tx_valid);

  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
endmodule

bind txr_dma_engine txr_dma_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .tx_abort(tx_abort), .irq(irq)
);

// File: tb/txr_dma_engine_bench.sv
module txr_dma_engine_bench;
  localparam int AW   = 16;
  localparam int RLEN = 8;
  localparam int POLL = 64;
  localparam logic [31:0] F_OWN  = 32'h8000_0000;
  localparam logic [31:0] F_SOP  = 32'h4000_0000;
  localparam logic [31:0] F_EOP  = 32'h2000_0000;
  localparam logic [31:0] F_ERR  = 32'h1000_0000;
  localparam logic [31:0] F_UFLO = 32'h0800_0000;
  localparam logic [31:0] F_OK   = 32'h0400_0000;
  localparam logic [31:0] F_RTRY = 32'h0200_0000;

  // {len0[12], len1[12] (0 = single buffer), coll[4], retry_fail[1]}
  localparam logic [28:0] VEC [6] = '{
    {12'd5, 12'd0, 4'd0,  1'b0},
    {12'd4, 12'd0, 4'd1,  1'b0},
    {12'd3, 12'd6, 4'd2,  1'b0},
    {12'd1, 12'd1, 4'd15, 1'b1},
    {12'd9, 12'd0, 4'd0,  1'b1},
    {12'd2, 12'd7, 4'd3,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_demand = 1'b0;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_last, tx_abort, irq;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic mac_stat_valid;
  logic [3:0] mac_coll = 4'd0;
  logic mac_retry_fail = 1'b0;

  logic [31:0] mem [256];
  logic host_we = 1'b0;
  logic [7:0] host_addr = 8'd0;
  logic [31:0] host_data = 32'd0;
  logic stall_en = 1'b0;
  logic [7:0] rx_buf [256];
  int rx_n = 0, last_cnt = 0, last_pos = 0, abort_cnt = 0, irq_cnt = 0;
  int wr_cnt = 0, bad_rd = 0, hold_viol = 0, cyc = 0;
  logic [2:0] sdelay = 3'd0;
  logic held_q = 1'b0;
  logic [8:0] held_val = 9'd0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int idx = 0;

  always #5 clk = ~clk;

  txr_dma_engine #(.AW(AW), .RING_BASE(0), .RING_LEN(RLEN), .POLL_CYCLES(POLL)) u_txr_dma_engine (
    .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_ready(tx_ready), .tx_abort(tx_abort),
    .mac_stat_valid(mac_stat_valid), .mac_coll(mac_coll),
    .mac_retry_fail(mac_retry_fail), .irq(irq)
  );

  // memory model: one-cycle acknowledge; host writes share the process
  always @(posedge clk) begin
    if (host_we) mem[host_addr] <= host_data;
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else if (mem_addr >= 16 && mem_addr < 64) begin
        bad_rd <= bad_rd + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // MAC model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) begin
      rx_buf[rx_n[7:0]] <= tx_data;
      rx_n <= rx_n + 1;
      if (tx_last) begin
        last_cnt <= last_cnt + 1;
        last_pos <= rx_n;
        sdelay   <= 3'd3;
      end
    end else if (sdelay != 0) begin
      sdelay <= sdelay - 1'b1;
    end
    mac_stat_valid <= (sdelay == 3'd1);
    if (tx_abort) abort_cnt <= abort_cnt + 1;
    if (irq) irq_cnt <= irq_cnt + 1;
    if (held_q && !(tx_valid && {tx_data, tx_last} == held_val)) hold_viol <= hold_viol + 1;
    held_q   <= tx_valid && !tx_ready;
    held_val <= {tx_data, tx_last};
  end

  always @(negedge clk) tx_ready <= stall_en ? (cyc % 3 != 0) : 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input int a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 8'(a); host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic demand();
    @(negedge clk); tx_demand = 1'b1;
    @(negedge clk); tx_demand = 1'b0;
  endtask

  task automatic wait_irq(input int target, input string tag);
    for (int t = 0; t < 3000 && irq_cnt < target; t++) @(negedge clk);
    chk(irq_cnt >= target, tag, 32'(irq_cnt), 32'(target));
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int v, input int k);
    return 8'(v * 37 + k * 5 + 1);
  endfunction

  function automatic int bufa(input int i);
    return 64 + i * 16;
  endfunction

  // load a buffer for descriptor i with frame bytes starting at frame offset k0
  task automatic load_buf(input int i, input int v, input int k0, input int len);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] d;
      for (int l = 0; l < 4; l++) d[8*l +: 8] = pat(v, k0 + 4 * w + l);
      host_write(bufa(i) + w, d);
    end
  endtask

  initial begin
    for (int t = 0; t < 100000 && !done; t++) @(negedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'd0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !tx_valid && !tx_abort && !irq, "R1 quiet in reset",
        {28'd0, mem_req, tx_valid, tx_abort, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_req && !tx_valid && !tx_abort && !irq, "R1 quiet after reset",
        {28'd0, mem_req, tx_valid, tx_abort, irq}, 32'd0);

    // table of frames
    for (int v = 0; v < 6; v++) begin
      int len0, len1, tot, n0, l0, i0, i1, irq0, mism;
      logic [3:0] cl;
      logic rt;
      logic [31:0] expw;
      len0 = int'(VEC[v][28:17]); len1 = int'(VEC[v][16:5]);
      cl = VEC[v][4:1]; rt = VEC[v][0];
      stall_en = v[0];
      mac_coll = cl; mac_retry_fail = rt;
      tot = len0 + len1; n0 = rx_n; l0 = last_cnt; irq0 = irq_cnt;
      i0 = idx; i1 = (idx + 1) % RLEN;
      load_buf(i0, v, 0, len0);
      host_write(2 * i0 + 1, 32'(bufa(i0)));
      if (len1 != 0) begin
        load_buf(i1, v, len0, len1);
        host_write(2 * i1 + 1, 32'(bufa(i1)));
        host_write(2 * i1, F_OWN | F_EOP | 32'(len1));
        host_write(2 * i0, F_OWN | F_SOP | 32'(len0));
      end else begin
        host_write(2 * i0, F_OWN | F_SOP | F_EOP | 32'(len0));
      end
      demand();
      wait_irq(irq0 + 1, "R6 frame interrupt");
      chk(irq_cnt == irq0 + 1, "R6 one irq per frame", 32'(irq_cnt), 32'(irq0 + 1));
      chk(rx_n - n0 == tot, "R3 byte count", 32'(rx_n - n0), 32'(tot));
      mism = 0;
      for (int k = 0; k < tot; k++) if (rx_buf[8'(n0 + k)] != pat(v, k)) mism++;
      chk(mism == 0, "R3 byte order and lanes", 32'(mism), 32'd0);
      chk(last_cnt == l0 + 1 && last_pos == n0 + tot - 1, "R4 last on final byte",
          32'(last_pos), 32'(n0 + tot - 1));
      if (len1 != 0) begin
        chk(mem[2 * i0] == (F_SOP | 32'(len0)), "R4 chained descriptor only released",
            mem[2 * i0], F_SOP | 32'(len0));
        expw = F_EOP | 32'(len1);
      end else begin
        expw = F_SOP | F_EOP | 32'(len0);
      end
      expw = expw | (rt ? F_RTRY : F_OK) | (32'(cl) << 20);
      chk(mem[2 * (len1 != 0 ? i1 : i0)] == expw, "R5 end descriptor status",
          mem[2 * (len1 != 0 ? i1 : i0)], expw);
      idx = (idx + (len1 != 0 ? 2 : 1)) % RLEN;
    end
    stall_en = 1'b0;
    chk(bad_rd == 0, "R9 ring wraps without reading past it", 32'(bad_rd), 32'd0);
    chk(hold_viol == 0, "R11 byte held under backpressure", 32'(hold_viol), 32'd0);

    // unowned descriptor
    begin
      int w0, n0, q0;
      host_write(2 * idx, 32'h0000_0004);
      w0 = wr_cnt; n0 = rx_n; q0 = irq_cnt;
      demand();
      repeat (30) @(negedge clk);
      chk(wr_cnt == w0 && rx_n == n0 && irq_cnt == q0, "R2 unowned descriptor untouched",
          32'(wr_cnt - w0 + rx_n - n0 + irq_cnt - q0), 32'd0);
      chk(mem[2 * idx] == 32'h4, "R2 unowned word unchanged", mem[2 * idx], 32'h4);
    end

    // framing error followed by a good frame
    begin
      int n0, q0, i1;
      i1 = (idx + 1) % RLEN;
      n0 = rx_n; q0 = irq_cnt;
      mac_coll = 4'd0; mac_retry_fail = 1'b0;
      load_buf(i1, 9, 0, 2);
      host_write(2 * i1 + 1, 32'(bufa(i1)));
      host_write(2 * i1, F_OWN | F_SOP | F_EOP | 32'd2);
      host_write(2 * idx + 1, 32'(bufa(idx)));
      host_write(2 * idx, F_OWN | 32'd4);
      demand();
      wait_irq(q0 + 2, "R7 error then next frame interrupts");
      chk(mem[2 * idx] == (F_ERR | 32'd4), "R7 framing error marked", mem[2 * idx], F_ERR | 32'd4);
      chk(rx_n - n0 == 2, "R7 no bytes from bad descriptor", 32'(rx_n - n0), 32'd2);
      chk(mem[2 * i1] == (F_SOP | F_EOP | F_OK | 32'd2), "R7 engine moved on",
          mem[2 * i1], F_SOP | F_EOP | F_OK | 32'd2);
      idx = (idx + 2) % RLEN;
    end

    // underrun in the middle of a frame
    begin
      int n0, q0, a0, l0, i1;
      i1 = (idx + 1) % RLEN;
      n0 = rx_n; q0 = irq_cnt; a0 = abort_cnt; l0 = last_cnt;
      host_write(2 * i1, 32'd0);
      load_buf(idx, 11, 0, 3);
      host_write(2 * idx + 1, 32'(bufa(idx)));
      host_write(2 * idx, F_OWN | F_SOP | 32'd3);
      demand();
      wait_irq(q0 + 1, "R8 underrun interrupt");
      chk(abort_cnt == a0 + 1, "R8 abort pulse", 32'(abort_cnt), 32'(a0 + 1));
      chk(mem[2 * idx] == (F_SOP | F_ERR | F_UFLO | 32'd3), "R8 underrun status",
          mem[2 * idx], F_SOP | F_ERR | F_UFLO | 32'd3);
      chk(rx_n - n0 == 3 && last_cnt == l0, "R8 partial frame without last",
          32'(rx_n - n0), 32'd3);
      idx = i1;
    end

    // pickup by polling only, on the descriptor the engine waits on
    begin
      int q0, n0;
      q0 = irq_cnt; n0 = rx_n;
      load_buf(idx, 13, 0, 1);
      host_write(2 * idx + 1, 32'(bufa(idx)));
      host_write(2 * idx, F_OWN | F_SOP | F_EOP | 32'd1);
      for (int t = 0; t < 3 * POLL && irq_cnt == q0; t++) @(negedge clk);
      chk(irq_cnt == q0 + 1 && rx_n == n0 + 1, "R10 poll finds frame without demand",
          32'(irq_cnt - q0), 32'd1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule